// File: doc/BRIEF.md
# Fixed-Point Format Requantizer

This block takes a signed two's complement fixed-point sample in one Q format and returns the same quantity in another Q format in a single pass. Four parameters set the format. `IN_INT` and `IN_FRAC` give the integer bits (including the sign) and the fraction bits of the input. `OUT_INT` and `OUT_FRAC` do the same for the output. On the fraction side, extra low bits are added as zeros. Surplus low bits are either cut off or rounded and then cut, as selected per sample. On the integer side, a wider field is filled by copying the sign. A narrower field either clamps to the output limits or keeps only the low bits, also selected per sample.

Samples travel on a valid/ready stream with one output register. An input is taken on a rising clock edge when `in_valid` and `in_ready` are both high. Its result is presented on the next cycle. `in_ready` is high whenever the output register is empty or is being emptied in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the output word and the flag stay frozen and no new sample is taken. A producer whose sample is not taken keeps `in_valid`, `in_data` and both mode bits steady until it is.

Top module: `qfx_requant`

## Requirements
- R1: While reset is applied and directly after it, `out_valid` is 0 and `in_ready` is 1.
- R2: With `rnd_mode`=0, surplus fraction bits are cut, so the result is the input value rounded toward minus infinity to the output step. With the default formats (Q4.6 in, Q3.3 out), the result code is floor(x/8), where x is the input code.
- R3: With `rnd_mode`=1, a one is added at the bit just below the cut and then the bits are cut. Halfway values therefore move toward plus infinity: the result code is floor((x+4)/8) by default.
- R4: With `sat_mode`=1, a result above the largest output code becomes 2^(OUT_W-1)-1 (31 by default). A result below the most negative code becomes -2^(OUT_W-1) (-32, i.e. 6'b100000). In both cases `out_ovf` is 1.
- R5: With `sat_mode`=0, an out-of-range result keeps only its low OUT_W bits, and `out_ovf` is 0.
- R6: Rounding is done before the range test. A rounding carry that passes the largest code is clamped and flagged in saturate mode.
- R7: `out_ovf` is 0 whenever the result fits the output format, in either mode.
- R8: A sample taken on one edge is presented, with `out_valid` high, on the next edge. `out_valid` falls once the word is taken and no new sample arrives.
- R9: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0, and `out_data` and `out_ovf` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_data | input | IN_INT+IN_FRAC | Input sample, signed, in Q(IN_INT).(IN_FRAC) |
| rnd_mode | input | 1 | 1 = round then cut, 0 = cut only; sampled with the data |
| sat_mode | input | 1 | 1 = clamp out-of-range results, 0 = keep low bits; sampled with the data |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the output word this cycle |
| out_data | output | OUT_INT+OUT_FRAC | Result, signed, in Q(OUT_INT).(OUT_FRAC) |
| out_ovf | output | 1 | Result was clamped |

## Verification
Several properties are checked on every cycle. The stream protocol is one: the block is ready whenever the output is empty, a stalled word is frozen, and an accepted sample always yields a valid word next cycle. The other is that a raised overflow flag only ever comes with one of the two limit codes. The numeric mapping can only be shown by the bench's scenarios, which compare each word against a model of floor-based cutting, half-up rounding, clamping and wrapping. These scenarios include the cases where a rounding carry alone crosses the upper limit, where rounding pulls a value back inside the lower limit, and ties on both sides of zero.

// File: rtl/qfx_pkg.sv
package qfx_pkg;

  // Treatment of surplus fraction bits
  typedef enum logic {
    FRAC_CHOP  = 1'b0,
    FRAC_ROUND = 1'b1
  } frac_mode_e;

  // Treatment of surplus integer bits
  typedef enum logic {
    INT_WRAP  = 1'b0,
    INT_CLAMP = 1'b1
  } int_mode_e;

endpackage

// File: rtl/qfx_frac_align.sv
// Moves the binary point so the fraction field has OUT_FRAC bits.
// The output carries one more integer bit than the input so a rounding
// carry can never be lost here.
module qfx_frac_align
  import qfx_pkg::*;
#(
  parameter int IN_INT   = 4,
  parameter int IN_FRAC  = 6,
  parameter int OUT_FRAC = 3
) (
  input  logic [IN_INT+IN_FRAC-1:0]    din,
  input  frac_mode_e                   mode,
  output logic [IN_INT+1+OUT_FRAC-1:0] dout
);

  localparam int IN_W  = IN_INT + IN_FRAC;
  localparam int MID_W = IN_INT + 1 + OUT_FRAC;

  generate
    if (OUT_FRAC == IN_FRAC) begin : g_same
      frac_mode_e mode_unused;
      assign mode_unused = mode;
      always_comb dout = {din[IN_W-1], din};
    end else if (OUT_FRAC > IN_FRAC) begin : g_widen
      localparam int PAD = OUT_FRAC - IN_FRAC;
      frac_mode_e mode_unused;
      assign mode_unused = mode;
      always_comb dout = {din[IN_W-1], din, {PAD{1'b0}}};
    end else begin : g_trim
      localparam int DROP = IN_FRAC - OUT_FRAC;
      logic [MID_W-1:0] kept;
      logic             guard;
      logic             bump;
      always_comb begin
        kept  = {din[IN_W-1], din[IN_W-1:DROP]};
        guard = din[DROP-1];
        bump  = (mode == FRAC_ROUND) ? guard : 1'b0;
        dout  = kept + {{(MID_W-1){1'b0}}, bump};
      end
      if (DROP > 1) begin : g_low
        logic low_unused;
        assign low_unused = ^din[DROP-2:0];
      end
    end
  endgenerate

endmodule

// File: rtl/qfx_int_fit.sv
// Fits the integer field to the output width by sign copy, clamp or wrap.
module qfx_int_fit
  import qfx_pkg::*;
#(
  parameter int MID_W = 8,
  parameter int OUT_W = 6
) (
  input  logic [MID_W-1:0] din,
  input  int_mode_e        mode,
  output logic [OUT_W-1:0] dout,
  output logic             ovf
);

  localparam logic [OUT_W-1:0] POS_LIM = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] NEG_LIM = {1'b1, {(OUT_W-1){1'b0}}};

  generate
    if (MID_W <= OUT_W) begin : g_extend
      int_mode_e mode_unused;
      assign mode_unused = mode;
      always_comb begin
        dout = OUT_W'($signed(din));
        ovf  = 1'b0;
      end
    end else begin : g_trim
      localparam int TOP_W = MID_W - OUT_W + 1;
      logic [TOP_W-1:0] top;
      logic             fits;
      always_comb begin
        top  = din[MID_W-1:OUT_W-1];
        fits = (&top) | ~(|top);
        if (fits || mode == INT_WRAP) begin
          dout = din[OUT_W-1:0];
          ovf  = 1'b0;
        end else begin
          dout = din[MID_W-1] ? NEG_LIM : POS_LIM;
          ovf  = 1'b1;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/qfx_stage.sv
// Single output register with valid/ready flow control.
module qfx_stage #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] din,
  input  logic         dflag,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] dout,
  output logic         oflag
);

  logic         vld_q;
  logic [W-1:0] data_q;
  logic         flag_q;

  always_comb in_ready = !vld_q || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
      flag_q <= 1'b0;
    end else if (in_ready) begin
      vld_q <= in_valid;
      if (in_valid) begin
        data_q <= din;
        flag_q <= dflag;
      end
    end
  end

  assign out_valid = vld_q;
  assign dout      = data_q;
  assign oflag     = flag_q;

endmodule

// File: rtl/qfx_requant.sv
module qfx_requant
  import qfx_pkg::*;
#(
  parameter int IN_INT   = 4,
  parameter int IN_FRAC  = 6,
  parameter int OUT_INT  = 3,
  parameter int OUT_FRAC = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [IN_INT+IN_FRAC-1:0]   in_data,
  input  logic                        rnd_mode,
  input  logic                        sat_mode,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [OUT_INT+OUT_FRAC-1:0] out_data,
  output logic                        out_ovf
);

  localparam int MID_W = IN_INT + 1 + OUT_FRAC;
  localparam int OUT_W = OUT_INT + OUT_FRAC;

  logic [MID_W-1:0] aligned;
  logic [OUT_W-1:0] fitted;
  logic             fit_ovf;

  qfx_frac_align #(
    .IN_INT  (IN_INT),
    .IN_FRAC (IN_FRAC),
    .OUT_FRAC(OUT_FRAC)
  ) u_align (
    .din (in_data),
    .mode(frac_mode_e'(rnd_mode)),
    .dout(aligned)
  );

  qfx_int_fit #(
    .MID_W(MID_W),
    .OUT_W(OUT_W)
  ) u_fit (
    .din (aligned),
    .mode(int_mode_e'(sat_mode)),
    .dout(fitted),
    .ovf (fit_ovf)
  );

  qfx_stage #(
    .W(OUT_W)
  ) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .din      (fitted),
    .dflag    (fit_ovf),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .dout     (out_data),
    .oflag    (out_ovf)
  );

endmodule

// File: rtl/qfx_requant_chk.sv
module qfx_requant_chk #(
  parameter int OUT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_data,
  input logic             out_ovf
);

  localparam logic [OUT_W-1:0] POS_LIM = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] NEG_LIM = {1'b1, {(OUT_W-1){1'b0}}};

  AST_EMPTY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R9

  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_ovf))); // R9

  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R9

  AST_TAKE_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R8

  AST_EMPTY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid); // R8

  AST_OVF_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ovf) |-> (out_data == POS_LIM || out_data == NEG_LIM)); // R4

endmodule

bind qfx_requant qfx_requant_chk #(
  .OUT_W(OUT_INT + OUT_FRAC)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data),
  .out_ovf  (out_ovf)
);

// File: tb/qfx_requant_test.sv
module qfx_requant_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [9:0] in_data = '0;
  logic       rnd_mode = 1'b0;
  logic       sat_mode = 1'b0;
  logic       out_ready = 1'b0;
  logic       in_ready;
  logic       out_valid;
  logic [5:0] out_data;
  logic       out_ovf;

  int nvec = 0;
  int nbad = 0;
  bit finished = 0;
  int     exp_q[$];
  string  lab_q[$];

  always #2 clk = ~clk;

  qfx_requant uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .rnd_mode(rnd_mode), .sat_mode(sat_mode),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_ovf(out_ovf)
  );

  task automatic check(bit ok, string req, int act, int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Expected {ovf, code[5:0]} for Q4.6 -> Q3.3
  function automatic int model(int x, bit rnd, bit sat);
    int v;
    int y;
    bit o;
    v = rnd ? ((x + 4) >>> 3) : (x >>> 3);
    o = 1'b0;
    y = v;
    if ((v > 31 || v < -32) && sat) begin
      y = (v > 31) ? 31 : -32;
      o = 1'b1;
    end
    return (int'(o) << 6) | (y & 63);
  endfunction

  function automatic string label(int x, bit rnd, bit sat);
    int v;
    int t;
    v = rnd ? ((x + 4) >>> 3) : (x >>> 3);
    t = x >>> 3;
    if (v > 31 || v < -32) begin
      if (!sat) return "R5";
      if (rnd && t <= 31 && t >= -32) return "R6";
      return "R4";
    end
    return rnd ? "R3 R7" : "R2 R7";
  endfunction

  task automatic sample_edge();
    #1;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected word", {25'd0, out_ovf, out_data}, -1);
      end else begin
        int e;
        string l;
        e = exp_q.pop_front();
        l = lab_q.pop_front();
        check({out_ovf, out_data} == e[6:0], l, {25'd0, out_ovf, out_data}, e);
      end
    end
  endtask

  task automatic send(int x, bit rnd, bit sat, bit rand_rdy);
    bit done;
    done = 1'b0;
    while (!done) begin
      @(negedge clk);
      in_valid  = 1'b1;
      in_data   = x[9:0];
      rnd_mode  = rnd;
      sat_mode  = sat;
      out_ready = rand_rdy ? (($urandom % 4) != 0) : 1'b1;
      sample_edge();
      if (in_ready) begin
        exp_q.push_back(model(x, rnd, sat));
        lab_q.push_back(label(x, rnd, sat));
        done = 1'b1;
      end
    end
  endtask

  task automatic idle(bit rand_rdy);
    @(negedge clk);
    in_valid  = 1'b0;
    out_ready = rand_rdy ? (($urandom % 2) != 0) : 1'b1;
    sample_edge();
  endtask

  task automatic drain();
    for (int i = 0; i < 20; i++) idle(1'b0);
    check(exp_q.size() == 0, "R8 words lost", exp_q.size(), 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  endtask

  initial begin
    #800000;
    nvec++;
    nbad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1: state under reset
    check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);

    // R8: latency of one cycle, then empty
    in_valid = 1'b1; in_data = 10'd8; rnd_mode = 0; sat_mode = 1; out_ready = 1'b0;
    #1 check(out_valid == 1'b0, "R8 not early", out_valid, 0);
    @(negedge clk);
    in_valid = 1'b0;
    #1 check(out_valid == 1'b1 && out_data == 6'd1, "R8 one cycle", {out_valid, out_data}, 7'h41);
    @(negedge clk);
    out_ready = 1'b1;
    @(negedge clk);
    #1 check(out_valid == 1'b0, "R8 empty after take", out_valid, 0);

    // R9: stall freezes the word and blocks input
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_data = 10'd16;
    @(negedge clk);
    in_data = 10'd24;
    #1 check(in_ready == 1'b0, "R9 blocked", in_ready, 0);
    @(negedge clk);
    #1 check(out_data == 6'd2 && in_ready == 1'b0, "R9 frozen", {in_ready, out_data}, 2);
    @(negedge clk);
    out_ready = 1'b1;
    #1 check(in_ready == 1'b1 && out_data == 6'd2, "R9 released", {in_ready, out_data}, 7'h42);
    @(negedge clk);
    in_valid = 1'b0;
    #1 check(out_valid == 1'b1 && out_data == 6'd3, "R9 next word", {out_valid, out_data}, 7'h43);
    @(negedge clk);

    // Directed corner cases
    send(252, 0, 1, 0);   // R2 top code, fits
    send(252, 1, 1, 0);   // R6 carry crosses upper limit
    send(252, 1, 0, 0);   // R5 carry wraps to -32
    send(-257, 0, 1, 0);  // R4 below lower limit
    send(-257, 1, 1, 0);  // R7 rounding brings it back inside
    send(511, 1, 1, 0);   // R4 largest input
    send(-512, 0, 0, 0);  // R5 smallest input wraps
    send(-512, 0, 1, 0);  // R4 smallest input clamps
    send(12, 1, 1, 0);    // R3 positive tie goes up
    send(-12, 1, 1, 0);   // R3 negative tie goes up
    send(-12, 0, 1, 0);   // R2 cut toward minus infinity
    send(0, 1, 0, 0);     // R7 zero
    drain();

    // Constrained random traffic with back-pressure
    for (int n = 0; n < 400; n++) begin
      int x;
      x = int'($urandom % 1024) - 512;
      if (($urandom % 3) == 0) x = int'($urandom % 80) - 40;
      send(x, 1'($urandom), 1'($urandom), 1'b1);
      if (($urandom % 4) == 0) idle(1'b1);
    end
    drain();
    finish_run();
  end

endmodule